// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block owns the program counter of a small processor and steers it for the flow-control instruction group. Each cycle the decoder presents one operation kind, together with a condition bit, the truth flag, an 8-bit immediate and a register operand. The sequencer then picks the next address. That address is sequential, a relative or absolute branch target, a table offset, a call target, or a return address restored from the stack.

A branch has one delay slot: the instruction that follows a taken branch always runs. Calls and return-from-interrupt are multicycle. While one runs, a stall output tells fetch and decode to hold. A call saves the address of the call into the link register. A return pops the status value and then the link value through a simple one-cycle-latency read port, moves the stack pointer past both words, and jumps to the restored link value. A trap raises a one-cycle interrupt request that carries a number taken from the immediate.

Top module: `pc_flow_ctl`

## Requirements
- R1: After reset `pc` equals RESET_PC (0), `link` is 0, `status` is 0, `sp` equals SP_RESET (0x0200), and `stall`, `irq_req` and `stk_rd_req` are low.
- R2: The `op_kind` codes are 0 sequential, 1 branch-offset, 2 branch-register, 3 branch-table, 4 call-offset, 5 call-register, 6 trap, 7 return. A sequential operation, or an untaken branch or call, advances `pc` by 2 in the next cycle.
- R3: A branch or call is taken when `cond_bit` is 0, or when `cond_bit` is 1 and `truth_flag` is 1.
- R4: Offset branches and offset calls target the address of the issuing instruction plus the sign-extended `imm8` times 2, modulo 2^ADDR_W.
- R5: Register branches and register calls target `reg_val` shifted left by one bit.
- R6: A table branch targets the address of the issuing instruction plus `reg_val` shifted left by one bit.
- R7: After a taken branch at address p, `pc` is p+2 for one cycle (delay slot) and then the target. A flow-control operation presented in the delay slot has no effect.
- R8: A taken call takes two cycles. In the cycle after issue, `stall` is 1, `pc` still holds the call address, and `link` holds that address. One cycle later `pc` is the target and `stall` is 0.
- R9: A trap raises `irq_req` for exactly the next cycle, with `irq_num` equal to the low TRAP_W bits of `imm8`, and `pc` advances by 2.
- R10: A return takes five cycles. It issues a read at `sp` (the status word) and then a read at `sp`+4 (the link word), each answered on `stk_rd_data` one cycle after the request. `status` takes the low SR_W bits of the first word, `link` takes the second word, `sp` grows by 8, and `pc` becomes the restored link value.
- R11: While `stall` is 1, the operation inputs are ignored. During the return's first three stalled cycles `pc` does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 3 | Operation kind code of the issuing instruction |
| cond_bit | input | 1 | Conditional-execution bit |
| truth_flag | input | 1 | Current truth flag |
| imm8 | input | 8 | Signed offset or trap number |
| reg_val | input | ADDR_W | Register operand |
| stk_rd_data | input | ADDR_W | Stack read data, one cycle after a request |
| pc | output | ADDR_W | Address of the instruction being issued |
| stall | output | 1 | Hold fetch and decode |
| link | output | ADDR_W | Link register |
| status | output | SR_W | Status register restored by a return |
| sp | output | ADDR_W | Stack pointer |
| stk_rd_req | output | 1 | Stack read request |
| stk_addr | output | ADDR_W | Stack read address |
| irq_req | output | 1 | Trap interrupt request pulse |
| irq_num | output | TRAP_W | Trap interrupt number |

## Verification
Every result arrives on a fixed cycle. The slot address is due one clock edge after a branch and the target one edge later. A call shows stall and the link value after one edge and the target after two. A trap pulse shows up after one edge. A return produces four stalled cycles and then the restored state on the fifth edge. The bench drives inputs on the falling edge and compares on the next falling edge, so each comparison sits exactly that many rising edges after its stimulus. The bench sweeps every offset immediate under every condition and flag pairing, and keeps the expected address in its own arithmetic. The stack model answers with a value computed from the request address, so the bench knows which word belongs to which pop.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    typedef enum logic [2:0] {
        OP_SEQ      = 3'd0,
        OP_BR_OFF   = 3'd1,
        OP_BR_REG   = 3'd2,
        OP_BR_TAB   = 3'd3,
        OP_CALL_OFF = 3'd4,
        OP_CALL_REG = 3'd5,
        OP_TRAP     = 3'd6,
        OP_RETI     = 3'd7
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_SLOT   = 3'd1,
        ST_CALL   = 3'd2,
        ST_POP_SR = 3'd3,
        ST_POP_LR = 3'd4,
        ST_CAP_LR = 3'd5,
        ST_JUMP   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/pcf_target.sv
module pcf_target
    import pcf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  op_kind_e            kind,
    input  logic                cond_bit,
    input  logic                truth_flag,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [7:0]          imm8,
    input  logic [ADDR_W-1:0]   reg_val,
    output logic                is_branch,
    output logic                is_call,
    output logic                taken,
    output logic [ADDR_W-1:0]   target
);
    localparam int EXT_W = ADDR_W - 8;

    logic [ADDR_W-1:0] off_scaled;
    logic [ADDR_W-1:0] reg_scaled;
    logic              cond_ok;

    always_comb begin
        off_scaled = {{EXT_W{imm8[7]}}, imm8} << 1;
        reg_scaled = reg_val << 1;
        cond_ok    = !cond_bit || truth_flag;
        is_branch  = 1'b0;
        is_call    = 1'b0;
        target     = pc + ADDR_W'(2);
        case (kind)
            OP_BR_OFF:   begin is_branch = 1'b1; target = pc + off_scaled; end
            OP_BR_REG:   begin is_branch = 1'b1; target = reg_scaled;      end
            OP_BR_TAB:   begin is_branch = 1'b1; target = pc + reg_scaled; end
            OP_CALL_OFF: begin is_call   = 1'b1; target = pc + off_scaled; end
            OP_CALL_REG: begin is_call   = 1'b1; target = reg_scaled;      end
            default:     ;
        endcase
        taken = (is_branch || is_call) && cond_ok;
    end
endmodule

// File: rtl/pcf_irq.sv
module pcf_irq #(
    parameter int TRAP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [TRAP_W-1:0] num_in,
    output logic              irq_req,
    output logic [TRAP_W-1:0] irq_num
);
    typedef struct packed {
        logic              req;
        logic [TRAP_W-1:0] num;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d     = irq_q;
        irq_d.req = fire;
        if (fire) irq_d.num = num_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_req = irq_q.req;
    assign irq_num = irq_q.num;

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(fire));
endmodule

// File: rtl/pc_flow_ctl.sv
module pc_flow_ctl
    import pcf_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              SR_W     = 8,
    parameter int              TRAP_W   = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    parameter logic [ADDR_W-1:0] SP_RESET = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_kind,
    input  logic              cond_bit,
    input  logic              truth_flag,
    input  logic [7:0]        imm8,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] stk_rd_data,
    output logic [ADDR_W-1:0] pc,
    output logic              stall,
    output logic [ADDR_W-1:0] link,
    output logic [SR_W-1:0]   status,
    output logic [ADDR_W-1:0] sp,
    output logic              stk_rd_req,
    output logic [ADDR_W-1:0] stk_addr,
    output logic              irq_req,
    output logic [TRAP_W-1:0] irq_num
);
    localparam logic [ADDR_W-1:0] STEP_PC = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_SP = ADDR_W'(4);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] lr;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] tgt;
        logic [SR_W-1:0]   sr;
    } seq_t;

    seq_t s_d, s_q;

    op_kind_e          kind;
    logic              is_branch, is_call, taken;
    logic [ADDR_W-1:0] target;
    logic              trap_fire;

    assign kind = op_kind_e'(op_kind);

    pcf_target #(.ADDR_W(ADDR_W)) i_target (
        .kind       (kind),
        .cond_bit   (cond_bit),
        .truth_flag (truth_flag),
        .pc         (s_q.pc),
        .imm8       (imm8),
        .reg_val    (reg_val),
        .is_branch  (is_branch),
        .is_call    (is_call),
        .taken      (taken),
        .target     (target)
    );

    assign trap_fire = (s_q.st == ST_RUN) && (kind == OP_TRAP);

    pcf_irq #(.TRAP_W(TRAP_W)) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (trap_fire),
        .num_in  (imm8[TRAP_W-1:0]),
        .irq_req (irq_req),
        .irq_num (irq_num)
    );

    always_comb begin
        s_d        = s_q;
        stk_rd_req = 1'b0;
        stk_addr   = s_q.sp;
        case (s_q.st)
            ST_RUN: begin
                s_d.pc = s_q.pc + STEP_PC;
                if (taken && is_branch) begin
                    s_d.tgt = target;
                    s_d.st  = ST_SLOT;
                end else if (taken && is_call) begin
                    s_d.pc  = s_q.pc;
                    s_d.lr  = s_q.pc;
                    s_d.tgt = target;
                    s_d.st  = ST_CALL;
                end else if (kind == OP_RETI) begin
                    s_d.pc = s_q.pc;
                    s_d.st = ST_POP_SR;
                end
            end
            ST_SLOT, ST_CALL: begin
                s_d.pc = s_q.tgt;
                s_d.st = ST_RUN;
            end
            ST_POP_SR: begin
                stk_rd_req = 1'b1;
                s_d.sp     = s_q.sp + STEP_SP;
                s_d.st     = ST_POP_LR;
            end
            ST_POP_LR: begin
                stk_rd_req = 1'b1;
                s_d.sr     = stk_rd_data[SR_W-1:0];
                s_d.sp     = s_q.sp + STEP_SP;
                s_d.st     = ST_CAP_LR;
            end
            ST_CAP_LR: begin
                s_d.lr = stk_rd_data;
                s_d.st = ST_JUMP;
            end
            ST_JUMP: begin
                s_d.pc = s_q.lr;
                s_d.st = ST_RUN;
            end
            default: s_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= ST_RUN;
            s_q.pc  <= RESET_PC;
            s_q.lr  <= '0;
            s_q.sp  <= SP_RESET;
            s_q.tgt <= '0;
            s_q.sr  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc     = s_q.pc;
    assign link   = s_q.lr;
    assign status = s_q.sr;
    assign sp     = s_q.sp;
    assign stall  = (s_q.st != ST_RUN) && (s_q.st != ST_SLOT);

    // R7
    slot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SLOT) |-> (pc == $past(pc) + STEP_PC));

    // R8
    call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_CALL) |-> (link == pc && stall));

    // R10
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_rd_req |=> (sp == $past(sp) + STEP_SP));

    // R11
    hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_POP_SR || s_q.st == ST_POP_LR || s_q.st == ST_CAP_LR)
        |=> $stable(pc));
endmodule

// File: tb/test_pc_flow_ctl.sv
module test_pc_flow_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic        cond_bit = 1'b0;
    logic        truth_flag = 1'b0;
    logic [7:0]  imm8 = 8'd0;
    logic [15:0] reg_val = 16'd0;
    logic [15:0] stk_rd_data = 16'd0;
    logic [15:0] pc, link, sp, stk_addr;
    logic [7:0]  status;
    logic        stall, stk_rd_req, irq_req;
    logic [3:0]  irq_num;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [15:0] exp_pc, exp_lr, exp_sp;

    pc_flow_ctl i_pc_flow_ctl (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .cond_bit(cond_bit),
        .truth_flag(truth_flag), .imm8(imm8), .reg_val(reg_val),
        .stk_rd_data(stk_rd_data), .pc(pc), .stall(stall), .link(link),
        .status(status), .sp(sp), .stk_rd_req(stk_rd_req), .stk_addr(stk_addr),
        .irq_req(irq_req), .irq_num(irq_num)
    );

    always #10 clk = ~clk;

    // stack model: word content is a function of its address
    always @(posedge clk) if (stk_rd_req) stk_rd_data <= stk_addr ^ 16'h5A3C;

    function automatic logic [15:0] soff(input logic [7:0] v);
        return {{8{v[7]}}, v} << 1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] k, input logic c, input logic t,
                         input logic [7:0] im, input logic [15:0] rv);
        op_kind = k; cond_bit = c; truth_flag = t; imm8 = im; reg_val = rv;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pc", pc, 0); chk("R1 link", link, 0); chk("R1 status", status, 0);
        chk("R1 sp", sp, 16'h0200); chk("R1 stall", stall, 0);
        chk("R1 irq", irq_req, 0); chk("R1 req", stk_rd_req, 0);
        exp_pc = 0; exp_lr = 0; exp_sp = 16'h0200;

        // R2 sequential advance
        for (int i = 0; i < 4; i++) begin
            drive(0, 0, 0, 8'hFF, 16'hFFFF); tick();
            exp_pc += 2; chk("R2 seq", pc, exp_pc);
        end

        // R3 R4 R7 offset branch, every immediate and cond/flag pair
        for (int im = 0; im < 256; im++)
            for (int ct = 0; ct < 4; ct++) begin
                logic [15:0] p;
                logic tk;
                p = exp_pc; tk = !ct[1] || ct[0];
                drive(1, ct[1], ct[0], 8'(im), 16'h0); tick();
                chk("R7 slot", pc, p + 2);
                if (tk) drive(1, 0, 0, 8'(im) ^ 8'h5F, 16'h0);
                else    drive(0, 0, 0, 8'h00, 16'h0);
                tick();
                exp_pc = tk ? p + soff(8'(im)) : p + 4;
                chk(tk ? "R4 offset target" : "R3 untaken", pc, exp_pc);
            end

        // R5 R6 register and table branches
        for (int i = 0; i < 64; i++)
            for (int ct = 0; ct < 4; ct++) begin
                logic [15:0] p, rv;
                logic tk;
                logic [2:0] k;
                p = exp_pc; rv = 16'(i * 1031 + 7); tk = !ct[1] || ct[0];
                k = i[0] ? 3'd3 : 3'd2;
                drive(k, ct[1], ct[0], 8'h12, rv); tick();
                chk("R7 slot reg", pc, p + 2);
                drive(0, 0, 0, 8'h00, 16'h0); tick();
                if (!tk)        exp_pc = p + 4;
                else if (i[0])  exp_pc = p + (rv << 1);
                else            exp_pc = rv << 1;
                chk(i[0] ? "R6 table target" : "R5 register target", pc, exp_pc);
            end

        // R8 calls
        for (int i = 0; i < 32; i++)
            for (int ct = 0; ct < 4; ct++) begin
                logic [15:0] p, rv;
                logic [7:0] im;
                logic tk;
                p = exp_pc; im = 8'(i * 37); rv = 16'(i * 517 + 3); tk = !ct[1] || ct[0];
                drive(i[0] ? 3'd5 : 3'd4, ct[1], ct[0], im, rv); tick();
                if (tk) begin
                    exp_lr = p;
                    chk("R8 stall", stall, 1); chk("R8 pc hold", pc, p);
                    chk("R8 link", link, p);
                    drive(1, 0, 0, 8'h40, 16'h0); tick();  // ignored while stalled
                    exp_pc = i[0] ? (rv << 1) : p + soff(im);
                    chk("R8 target", pc, exp_pc); chk("R8 stall end", stall, 0);
                end else begin
                    exp_pc = p + 2;
                    chk("R3 call untaken", pc, exp_pc); chk("R3 link kept", link, exp_lr);
                end
            end

        // R9 trap
        for (int i = 0; i < 16; i++) begin
            logic [7:0] im;
            im = 8'(i * 23 + 16);
            drive(6, 1, 0, im, 16'h0); tick();
            exp_pc += 2;
            chk("R9 irq", irq_req, 1); chk("R9 num", irq_num, im[3:0]);
            chk("R9 pc", pc, exp_pc);
            drive(0, 0, 0, 8'h0, 16'h0); tick();
            exp_pc += 2;
            chk("R9 pulse end", irq_req, 0);
        end

        // R10 R11 return from interrupt
        for (int i = 0; i < 4; i++) begin
            logic [15:0] p, s0;
            p = exp_pc; s0 = exp_sp;
            drive(7, 0, 0, 8'h0, 16'h0); tick();
            drive(1, 0, 0, 8'h20, 16'h0);  // must be ignored while stalled
            for (int k = 0; k < 4; k++) begin
                chk("R10 stall", stall, 1);
                if (k < 3) chk("R11 pc hold", pc, p);
                tick();
            end
            drive(0, 0, 0, 8'h0, 16'h0);
            exp_sp = s0 + 8;
            exp_pc = (s0 + 16'd4) ^ 16'h5A3C;
            exp_lr = exp_pc;
            chk("R10 stall end", stall, 0); chk("R10 pc", pc, exp_pc);
            chk("R10 link", link, exp_lr);
            chk("R10 status", status, 8'((s0 ^ 16'h5A3C) & 16'h00FF));
            chk("R10 sp", sp, exp_sp);
        end

        finish_run();
    end
endmodule